// File: doc/BRIEF.md
# Mesh Node Bus Interface

This block sits between a local processor bus and one node of a two-dimensional mesh interconnect. A single bus write becomes one outbound packet. The 32-bit write data is the payload. The write address supplies the destination coordinate, an optional control byte with its valid flag, and the port on which the packet makes its first hop. That port field steers the packet and is not stored in it. The packet leaves on one of four link ports (north, east, south, west), each with a valid/ready handshake. The bus write is held in a wait state until the chosen port takes the packet.

Packets delivered to this node arrive on an inbound valid/ready port and wait in a small receive queue. The processor collects them with ordinary bus reads. One read offset pops the payload. A second offset shows the head entry's header, its control byte and the queue flags, and does not pop. A write addressed to the node's own coordinate never reaches a link port: it goes straight into the node's own receive queue.

Top module: `mesh_node_bus_if`

## Requirements
- R1: A write whose destination differs from `nodeCoord` raises exactly one `txValid` bit. The bit is chosen by write address bits [3:2]: 0 selects bit 0 (north), 1 selects bit 1 (east), 2 selects bit 2 (south) and 3 selects bit 3 (west). While no write is pending, `txValid` is zero.
- R2: `txPkt` carries the payload in bits [31:0] (the write data) and the destination coordinate in bits [39:32] (address bits [11:4], Y in the upper nibble). Bits [47:40] hold the control byte (address bits [19:12]) and bit [48] holds the control-valid flag (address bit 20). When the flag is 0, bits [47:40] are zero.
- R3: `busWait` stays high while the selected port's `txReady` is low. The write completes in the cycle that port accepts, and each write yields exactly one accepted packet.
- R4: A write whose destination equals `nodeCoord` raises no `txValid`. Instead it places the packet in the receive queue.
- R5: The receive queue holds 4 entries in arrival order. `rxReady` is low while 4 entries are held. Inbound packets (same layout as `txPkt`) are taken when `rxValid` and `rxReady` are both high.
- R6: A read with address bit 2 clear returns the head payload and removes the head entry.
- R7: A read with address bit 2 set returns the status word without popping. Bit 0 is the empty flag, bit 1 is the sticky underflow flag, bits [15:8] are the head control byte, bit 16 is the head control-valid flag and bits [31:24] are the head destination coordinate. The head fields read zero when the queue is empty.
- R8: A payload read from an empty queue returns zero and sets the underflow flag. The flag stays set until reset.
- R9: A self-addressed write to a full queue holds `busWait` high. A self-addressed write takes priority over the inbound port: `rxReady` is low in any cycle that holds such a write.
- R10: After reset, `txValid` is zero, `rxReady` is high, the queue is empty and the underflow flag is clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| nodeCoord | input | 8 | This node's YX coordinate (static) |
| busSel | input | 1 | Bus cycle active |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 32 | Bus address with the packet fields |
| busWdata | input | 32 | Write data (payload) |
| busRdata | output | 32 | Read data |
| busWait | output | 1 | Holds the current write cycle |
| txValid | output | 4 | Outbound valid per port N,E,S,W |
| txReady | input | 4 | Outbound ready per port |
| txPkt | output | 49 | Outbound packet, shared by all ports |
| rxValid | input | 1 | Inbound packet valid |
| rxReady | output | 1 | Inbound packet accepted |
| rxPkt | input | 49 | Inbound packet |

## Verification
If the decoded port were wrong, the wrong `txValid` bit would rise in the same cycle as the write, before any edge. A corrupted queue pointer or count would show up one read later: a payload would come back out of arrival order, the empty bit would be wrong, or `rxReady` would be high or low on the wrong entry count. A lost underflow flag or a missed loopback priority would be visible in the next status read or in the same-cycle `rxReady` level. Each test therefore samples the ports in the cycle of the stimulus or in the read that follows it.

// File: rtl/mesh_node_pkg.sv
package mesh_node_pkg;
  localparam int DATA_W  = 32;
  localparam int COORD_W = 8;
  localparam int CTRL_W  = 8;
  localparam int ADDR_W  = 32;
  localparam int PORTS   = 4;

  // address field positions
  localparam int DIR_LSB  = 2;
  localparam int DEST_LSB = 4;
  localparam int CTRL_LSB = DEST_LSB + COORD_W;
  localparam int CVAL_BIT = CTRL_LSB + CTRL_W;
  localparam int SEL_STATUS_BIT = 2;

  typedef struct packed {
    logic              ctrlValid;
    logic [CTRL_W-1:0] ctrl;
    logic [COORD_W-1:0] dest;
    logic [DATA_W-1:0] payload;
  } pkt_t;

  localparam int PKT_W = $bits(pkt_t);

  typedef struct packed {
    logic [PORTS-1:0] launch;
    logic             loopPush;
    logic             inPush;
    logic             pop;
    logic             underflowSet;
    logic             stall;
  } strobe_t;
endpackage

// File: rtl/mesh_node_fifo.sv
module mesh_node_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         push,
  input  logic [W-1:0] pushData,
  input  logic         pop,
  output logic [W-1:0] headData,
  output logic         full,
  output logic         empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULLCNT = CNT_W'(DEPTH);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;

  assign full     = (count == FULLCNT);
  assign empty    = (count == '0);
  assign headData = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) begin
        wrPtr <= (wrPtr == LAST) ? '0 : wrPtr + 1'b1;
      end
      if (pop) begin
        rdPtr <= (rdPtr == LAST) ? '0 : rdPtr + 1'b1;
      end
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= pushData;
  end

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rstN)
    full |-> !push);
  p_no_empty_pop_r6: assert property (@(posedge clk) disable iff (!rstN)
    empty |-> !pop);
  p_fill_to_full_r5: assert property (@(posedge clk) disable iff (!rstN)
    (count == FULLCNT - 1'b1 && push && !pop) |=> full);
endmodule

// File: rtl/mesh_node_ctrl.sv
module mesh_node_ctrl
  import mesh_node_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [COORD_W-1:0] nodeCoord,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [PORTS-1:0]  txReady,
  input  logic              rxValid,
  input  logic              qFull,
  input  logic              qEmpty,
  output logic              rxReady,
  output strobe_t           stb
);
  logic              isWrite, isRead, isLoop, readsData;
  logic [1:0]        dirSel;
  logic [COORD_W-1:0] destYx;

  assign isWrite   = busSel && busWr;
  assign isRead    = busSel && !busWr;
  assign dirSel    = busAddr[DIR_LSB +: 2];
  assign destYx    = busAddr[DEST_LSB +: COORD_W];
  assign isLoop    = (destYx == nodeCoord);
  assign readsData = isRead && !busAddr[SEL_STATUS_BIT];

  // a self-addressed write owns the queue input this cycle
  assign rxReady = !qFull && !(isWrite && isLoop);

  always_comb begin
    stb              = '0;
    stb.launch       = (isWrite && !isLoop) ? (PORTS'(1) << dirSel) : '0;
    stb.loopPush     = isWrite && isLoop && !qFull;
    stb.inPush       = rxValid && rxReady;
    stb.pop          = readsData && !qEmpty;
    stb.underflowSet = readsData && qEmpty;
    stb.stall        = isWrite && (isLoop ? qFull : !txReady[dirSel]);
  end

  p_launch_onehot_r1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(stb.launch));
  p_loop_no_launch_r4: assert property (@(posedge clk) disable iff (!rstN)
    (isWrite && isLoop) |-> (stb.launch == '0));
  p_stall_unready_r3: assert property (@(posedge clk) disable iff (!rstN)
    (isWrite && !isLoop && !txReady[dirSel]) |-> stb.stall);
  p_loop_priority_r9: assert property (@(posedge clk) disable iff (!rstN)
    stb.loopPush |-> !stb.inPush);
endmodule

// File: rtl/mesh_node_datapath.sv
module mesh_node_datapath
  import mesh_node_pkg::*;
#(
  parameter int RX_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [PKT_W-1:0]  rxPkt,
  output logic [DATA_W-1:0] busRdata,
  output logic [PKT_W-1:0]  txPkt,
  output logic              qFull,
  output logic              qEmpty
);
  pkt_t outPkt, pushPkt, headPkt;
  logic [PKT_W-1:0] headRaw;
  logic underflowSticky;
  logic [1:0] unusedAddrLsb;
  logic [ADDR_W-CVAL_BIT-2:0] unusedAddrMsb;

  assign unusedAddrLsb = busAddr[1:0];
  assign unusedAddrMsb = busAddr[ADDR_W-1:CVAL_BIT+1];

  always_comb begin
    outPkt.ctrlValid = busAddr[CVAL_BIT];
    outPkt.ctrl      = busAddr[CVAL_BIT] ? busAddr[CTRL_LSB +: CTRL_W] : '0;
    outPkt.dest      = busAddr[DEST_LSB +: COORD_W];
    outPkt.payload   = busWdata;
  end

  assign txPkt   = outPkt;
  assign pushPkt = stb.loopPush ? outPkt : pkt_t'(rxPkt);

  mesh_node_fifo #(.W(PKT_W), .DEPTH(RX_DEPTH)) rxq_i (
    .clk      (clk),
    .rstN     (rstN),
    .push     (stb.loopPush || stb.inPush),
    .pushData (pushPkt),
    .pop      (stb.pop),
    .headData (headRaw),
    .full     (qFull),
    .empty    (qEmpty)
  );

  assign headPkt = pkt_t'(headRaw);

  always_ff @(posedge clk) begin
    if (!rstN)                 underflowSticky <= 1'b0;
    else if (stb.underflowSet) underflowSticky <= 1'b1;
  end

  always_comb begin
    busRdata = '0;
    if (busAddr[SEL_STATUS_BIT]) begin
      busRdata[0] = qEmpty;
      busRdata[1] = underflowSticky;
      if (!qEmpty) begin
        busRdata[15:8]  = headPkt.ctrl;
        busRdata[16]    = headPkt.ctrlValid;
        busRdata[31:24] = headPkt.dest;
      end
    end else if (!qEmpty) begin
      busRdata = headPkt.payload;
    end
  end

  p_underflow_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    underflowSticky |=> underflowSticky);
  p_empty_read_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    stb.underflowSet |-> (busRdata == '0));
  p_ctrl_cleared_r2: assert property (@(posedge clk) disable iff (!rstN)
    !outPkt.ctrlValid |-> (outPkt.ctrl == '0));
endmodule

// File: rtl/mesh_node_bus_if.sv
module mesh_node_bus_if
  import mesh_node_pkg::*;
#(
  parameter int RX_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [COORD_W-1:0] nodeCoord,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              busWait,
  output logic [PORTS-1:0]  txValid,
  input  logic [PORTS-1:0]  txReady,
  output logic [PKT_W-1:0]  txPkt,
  input  logic              rxValid,
  output logic              rxReady,
  input  logic [PKT_W-1:0]  rxPkt
);
  strobe_t stb;
  logic qFull, qEmpty;

  mesh_node_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .nodeCoord (nodeCoord),
    .busSel    (busSel),
    .busWr     (busWr),
    .busAddr   (busAddr),
    .txReady   (txReady),
    .rxValid   (rxValid),
    .qFull     (qFull),
    .qEmpty    (qEmpty),
    .rxReady   (rxReady),
    .stb       (stb)
  );

  mesh_node_datapath #(.RX_DEPTH(RX_DEPTH)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .rxPkt    (rxPkt),
    .busRdata (busRdata),
    .txPkt    (txPkt),
    .qFull    (qFull),
    .qEmpty   (qEmpty)
  );

  assign txValid = stb.launch;
  assign busWait = stb.stall;

  p_single_handshake_r3: assert property (@(posedge clk) disable iff (!rstN)
    (txValid != '0 && (txValid & txReady) == '0) |-> busWait);
endmodule

// File: tb/mesh_node_bus_if_tb.sv
module mesh_node_bus_if_tb_top;
  logic        clk = 1'b0;
  logic        rstN;
  logic [7:0]  nodeCoord;
  logic        busSel, busWr;
  logic [31:0] busAddr, busWdata, busRdata;
  logic        busWait;
  logic [3:0]  txValid, txReady;
  logic [48:0] txPkt, rxPkt;
  logic        rxValid, rxReady;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  mesh_node_bus_if dut_i (
    .clk(clk), .rstN(rstN), .nodeCoord(nodeCoord),
    .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .busWait(busWait),
    .txValid(txValid), .txReady(txReady), .txPkt(txPkt),
    .rxValid(rxValid), .rxReady(rxReady), .rxPkt(rxPkt)
  );

  localparam logic [7:0] OWN = 8'h24;

  function automatic logic [31:0] mkAddr(logic cv, logic [7:0] ctl,
                                         logic [7:0] dst, logic [1:0] dir);
    return {11'b0, cv, ctl, dst, dir, 2'b00};
  endfunction

  function automatic logic [48:0] mkPkt(logic cv, logic [7:0] ctl,
                                        logic [7:0] dst, logic [31:0] pay);
    return {cv, (cv ? ctl : 8'h00), dst, pay};
  endfunction

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    busSel = 0; busWr = 0; busAddr = '0; busWdata = '0;
    rxValid = 0; rxPkt = '0; txReady = 4'hF;
  endtask

  task automatic readBus(input logic status, output logic [31:0] v);
    @(negedge clk);
    busSel = 1; busWr = 0; busAddr = status ? 32'h4 : 32'h0;
    #1 v = busRdata;
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  task automatic pushIn(input logic [48:0] p);
    @(negedge clk);
    rxValid = 1; rxPkt = p;
    #1 chk("R5", "rxReady on push", rxReady, 1);
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  task automatic t_reset();
    logic [31:0] s;
    chk("R10", "txValid after reset", txValid, 0);
    chk("R10", "rxReady after reset", rxReady, 1);
    readBus(1, s);
    chk("R10", "status after reset", s, 32'h1);
  endtask

  task automatic t_launch();
    logic [7:0] dsts [4] = '{8'h31, 8'h57, 8'h00, 8'hFF};
    for (int d = 0; d < 4; d++) begin
      @(negedge clk);
      txReady = 4'hF & ~(4'b1 << d);
      busSel = 1; busWr = 1;
      busAddr = mkAddr(d[0], 8'hA0 + 8'(d), dsts[d], 2'(d));
      busWdata = 32'hC0DE_0000 + d;
      #1;
      chk("R1", "txValid port", txValid, 4'b1 << d);
      chk("R2", "txPkt fields", txPkt,
          mkPkt(d[0], 8'hA0 + 8'(d), dsts[d], 32'hC0DE_0000 + d));
      chk("R3", "wait while unready", busWait, 1);
      @(negedge clk);
      chk("R3", "wait still held", busWait, 1);
      txReady = 4'hF;
      #1 chk("R3", "wait released on accept", busWait, 0);
      @(posedge clk);
      @(negedge clk);
      idle();
      #1 chk("R1", "txValid after write", txValid, 0);
    end
  endtask

  task automatic t_loop();
    logic [31:0] s, d;
    @(negedge clk);
    busSel = 1; busWr = 1; busAddr = mkAddr(1, 8'h5A, OWN, 2'd1);
    busWdata = 32'h1234_5678;
    #1;
    chk("R4", "no launch on self write", txValid, 0);
    chk("R4", "no wait on self write", busWait, 0);
    @(posedge clk);
    @(negedge clk);
    idle();
    readBus(1, s);
    chk("R7", "status after loop", s, {OWN, 7'b0, 1'b1, 8'h5A, 8'h00});
    readBus(1, s);
    chk("R7", "status read does not pop", s[0], 0);
    readBus(0, d);
    chk("R6", "loop payload", d, 32'h1234_5678);
    readBus(1, s);
    chk("R6", "empty after pop", s[0], 1);
  endtask

  task automatic t_order();
    logic [31:0] d, s;
    for (int i = 0; i < 4; i++) pushIn(mkPkt(0, 0, OWN, 32'hAB00 + i));
    @(negedge clk);
    rxValid = 1; rxPkt = mkPkt(0, 0, OWN, 32'hDEAD);
    #1 chk("R5", "rxReady low when full", rxReady, 0);
    @(posedge clk);
    @(negedge clk);
    idle();
    for (int i = 0; i < 4; i++) begin
      readBus(0, d);
      chk("R6", "fifo order", d, 32'hAB00 + i);
    end
    readBus(1, s);
    chk("R5", "fifth packet not taken", s[0], 1);
  endtask

  task automatic t_priority();
    logic [31:0] d;
    for (int i = 0; i < 3; i++) pushIn(mkPkt(0, 0, OWN, 32'h7700 + i));
    @(negedge clk);
    rxValid = 1; rxPkt = mkPkt(0, 0, OWN, 32'hBAD0);
    busSel = 1; busWr = 1; busAddr = mkAddr(0, 0, OWN, 2'd0); busWdata = 32'h600D;
    #1;
    chk("R9", "rxReady low under self write", rxReady, 0);
    chk("R9", "self write not stalled", busWait, 0);
    @(posedge clk);
    @(negedge clk);
    idle();
    busSel = 1; busWr = 1; busAddr = mkAddr(0, 0, OWN, 2'd2); busWdata = 32'h0F0F;
    #1 chk("R9", "self write stalls when full", busWait, 1);
    @(posedge clk);
    @(negedge clk);
    idle();
    for (int i = 0; i < 3; i++) begin
      readBus(0, d);
      chk("R9", "inbound kept", d, 32'h7700 + i);
    end
    readBus(0, d);
    chk("R9", "self packet last", d, 32'h600D);
  endtask

  task automatic t_underflow();
    logic [31:0] d, s;
    readBus(0, d);
    chk("R8", "empty read zero", d, 0);
    readBus(1, s);
    chk("R8", "underflow set", s[1:0], 2'b11);
    pushIn(mkPkt(0, 0, OWN, 32'h1));
    readBus(1, s);
    chk("R8", "underflow sticky", s[1:0], 2'b10);
    readBus(0, d);
    chk("R6", "payload after underflow", d, 32'h1);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    nodeCoord = OWN;
    idle();
    rstN = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    #1;
    t_reset();
    t_launch();
    t_loop();
    t_order();
    t_priority();
    t_underflow();
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule